// File: doc/BRIEF.md
# Console Terminal Register Port

This block gives a processor a console terminal through four small registers on a register bus: a receive status word, a receive data word, a transmit status word and a transmit data word. Behind the registers sit a byte-wide receiver and a byte-wide transmitter, both modelled as valid/ready byte ports, plus a one-cycle break strobe from the line receiver. Each direction has a done flag and an interrupt enable, and drives its own level interrupt request.

The transmit data word carries a 4-bit unit field in bits 11:8. When that field is zero, the low byte goes out to the terminal transmitter. Any other value sends the write to a non-terminal unit instead, and the terminal is not driven. The value 0xF selects a console control command, and the low byte then names it. The four commands leave the block as one-cycle strobes.

On the receive side, a new character is held off while an unread character is waiting. The hold-off ends once a programmable number of cycles has passed since the last character was latched. A character taken in past the hold-off overwrites the waiting one and is marked as an overrun. Reading the receive data word consumes the character and wipes its error flags.

Top module: `con_term_port`

## Requirements
- R1: Register index 0 is receive status and index 2 is transmit status. Both read as DONE in bit 7 and IE in bit 6, with all other bits zero. A status write changes only IE, taken from write bit 6.
- R2: A status write with bit 6 clear drops that side's interrupt request on the next clock. A status write with bit 6 set, made while DONE is set and IE was clear, raises the request on the next clock.
- R3: A character is accepted when rx_valid and rx_ready are both high at a clock edge. After that edge the receive data word (index 1) holds the character in bits 7:0, receive DONE is set, and irq_rx is high if IE is set.
- R4: A break strobe that is accepted under the same rule loads the receive data word with 0xA000: error summary in bit 15, framing error in bit 13, and a zero character.
- R5: A read of the receive data word while DONE is set returns the stored word. After that clock, DONE is clear, bits 15:8 of the word are zero and irq_rx is low. A read while DONE is clear returns the word and has no effect.
- R6: A write to the transmit data word (index 3) stores all 16 bits, which read back at index 3. On the next clock, transmit DONE and irq_tx are low.
- R7: When write bits 11:8 are zero, tx_valid rises on the next clock with tx_byte equal to write bits 7:0. Both hold until tx_ready is high. After that handshake edge, transmit DONE is set and irq_tx follows IE.
- R8: When write bits 11:8 are nonzero, tx_valid stays low. Transmit DONE is clear for one cycle and is set again at the second clock after the write.
- R9: When write bits 11:8 are 0xF, the low byte values 1, 2, 3 and 4 pulse cmd_sw_done, cmd_reboot, cmd_clr_warm and cmd_clr_cold respectively, for the one cycle after the write. Any other value pulses no strobe.
- R10: rx_ready is low only while receive DONE is set and fewer than hold_cycles clock edges have passed since the last accepted character.
- R11: A character accepted while receive DONE is set (with no data read in the same cycle) sets bits 15 and 14 of the receive data word, in addition to the character.
- R12: After reset, receive status reads 0x0000, transmit status reads 0x0080, the receive data word reads 0x0000, and both interrupt requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 2 | Register index: 0 rx status, 1 rx data, 2 tx status, 3 tx data |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_rd | input | 1 | Read strobe; needed for the side effects of reading rx data |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register (combinational) |
| rx_valid | input | 1 | Receiver offers a character |
| rx_byte | input | 8 | Offered character |
| rx_break | input | 1 | Break detected on the line (one-cycle strobe) |
| rx_ready | output | 1 | Block will accept a character or break at this edge |
| hold_cycles | input | 16 | Hold-off length in clock cycles |
| tx_valid | output | 1 | Byte waiting for the transmitter |
| tx_byte | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Transmitter takes the byte |
| irq_rx | output | 1 | Receive interrupt request (level) |
| irq_tx | output | 1 | Transmit interrupt request (level) |
| cmd_sw_done | output | 1 | Software-done command strobe |
| cmd_reboot | output | 1 | Reboot command strobe |
| cmd_clr_warm | output | 1 | Clear-warm-start command strobe |
| cmd_clr_cold | output | 1 | Clear-cold-start command strobe |

## Verification
A done flag stuck in the wrong state shows up in the status read and in rx_ready on the very next cycle. A stale interrupt request is visible on irq_rx or irq_tx one clock after the status write or data read that should have changed it. A wrong decode of the unit field shows either as an unexpected tx_valid handshake or as a missing or extra command strobe in the cycle right after the write. The scoreboard catches both at once. Error bits left behind by a missed clear appear in the second read of the receive data word.

// File: rtl/con_term_pkg.sv
package con_term_pkg;
    localparam int CHAR_W   = 8;
    localparam int WORD_W   = 16;
    localparam int DONE_BIT = 7;
    localparam int IE_BIT   = 6;
    localparam int ERR_BIT  = 15;
    localparam int OVR_BIT  = 14;
    localparam int FRM_BIT  = 13;
    localparam int UNIT_LSB = 8;
    localparam int UNIT_W   = 4;
    localparam int FLD_W    = UNIT_LSB + UNIT_W;
    localparam int NUM_CMDS = 4;
    localparam logic [UNIT_W-1:0] UNIT_CTL = 4'hF;

    typedef enum logic [1:0] {
        REG_RX_STAT = 2'd0,
        REG_RX_DATA = 2'd1,
        REG_TX_STAT = 2'd2,
        REG_TX_DATA = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic                done;
        logic                ie;
        logic                irq;
        logic                pend;
        logic                ntu;
        logic [NUM_CMDS-1:0] cmd;
        logic [WORD_W-1:0]   word;
    } tx_state_t;
endpackage

// File: rtl/con_unit_decode.sv
module con_unit_decode
    import con_term_pkg::*;
(
    input  logic [FLD_W-1:0]    fld,
    output logic                to_term,
    output logic [NUM_CMDS-1:0] cmd_hot
);
    logic [UNIT_W-1:0] unit_sel;
    logic              is_ctl;

    assign unit_sel = fld[FLD_W-1:UNIT_LSB];
    assign to_term  = (unit_sel == '0);
    assign is_ctl   = (unit_sel == UNIT_CTL);

    for (genvar i = 0; i < NUM_CMDS; i++) begin : g_cmd
        assign cmd_hot[i] = is_ctl && (fld[CHAR_W-1:0] == CHAR_W'(i + 1));
    end
endmodule

// File: rtl/con_rx_side.sv
module con_rx_side
    import con_term_pkg::*;
#(
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_wr,
    input  logic              stat_ie,
    input  logic              data_rd,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_byte,
    input  logic              rx_break,
    input  logic [HOLD_W-1:0] hold_cycles,
    output logic              rx_ready,
    output logic              done,
    output logic              ie,
    output logic              irq,
    output logic [WORD_W-1:0] word
);
    localparam logic [HOLD_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic              done;
        logic              ie;
        logic              irq;
        logic [WORD_W-1:0] word;
        logic [HOLD_W-1:0] cnt;
    } rx_state_t;

    rx_state_t st_q, st_d;
    logic      accept;
    logic      expired;

    assign expired  = (st_q.cnt >= hold_cycles);
    assign rx_ready = !st_q.done || expired;
    assign accept   = rx_ready && (rx_valid || rx_break);

    always_comb begin
        st_d = st_q;
        if (stat_wr) st_d.ie = stat_ie;

        if (data_rd && st_q.done) begin
            st_d.done                = 1'b0;
            st_d.irq                 = 1'b0;
            st_d.word[WORD_W-1:CHAR_W] = '0;
        end

        if (accept) begin
            st_d.word = '0;
            if (rx_break) begin
                st_d.word[ERR_BIT] = 1'b1;
                st_d.word[FRM_BIT] = 1'b1;
            end else begin
                st_d.word[CHAR_W-1:0] = rx_byte;
            end
            if (st_q.done && !data_rd) begin
                st_d.word[ERR_BIT] = 1'b1;
                st_d.word[OVR_BIT] = 1'b1;
            end
            st_d.done = 1'b1;
            st_d.irq  = st_d.ie;
            st_d.cnt  = '0;
        end else if (st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end

        if (stat_wr) begin
            if (!stat_ie)                    st_d.irq = 1'b0;
            else if (st_q.done && !st_q.ie)  st_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done = st_q.done;
    assign ie   = st_q.ie;
    assign irq  = st_q.irq;
    assign word = st_q.word;
endmodule

// File: rtl/con_tx_side.sv
module con_tx_side
    import con_term_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stat_wr,
    input  logic                stat_ie,
    input  logic                data_wr,
    input  logic [WORD_W-1:0]   wdata,
    input  logic                tx_ready,
    output logic                tx_valid,
    output logic [CHAR_W-1:0]   tx_byte,
    output logic                done,
    output logic                ie,
    output logic                irq,
    output logic [WORD_W-1:0]   word,
    output logic [NUM_CMDS-1:0] cmd
);
    tx_state_t           st_q, st_d;
    logic                to_term;
    logic [NUM_CMDS-1:0] cmd_hot;

    con_unit_decode u_dec (
        .fld     (wdata[FLD_W-1:0]),
        .to_term (to_term),
        .cmd_hot (cmd_hot)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cmd = '0;
        if (stat_wr) st_d.ie = stat_ie;

        if (data_wr) begin
            st_d.word = wdata;
            st_d.done = 1'b0;
            st_d.irq  = 1'b0;
            st_d.pend = to_term;
            st_d.ntu  = !to_term;
            st_d.cmd  = cmd_hot;
        end else begin
            if (st_q.pend && tx_ready) begin
                st_d.pend = 1'b0;
                st_d.done = 1'b1;
                st_d.irq  = st_d.ie;
            end
            if (st_q.ntu) begin
                st_d.ntu  = 1'b0;
                st_d.done = 1'b1;
                st_d.irq  = st_d.ie;
            end
        end

        if (stat_wr) begin
            if (!stat_ie)                    st_d.irq = 1'b0;
            else if (st_q.done && !st_q.ie)  st_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.done <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_valid = st_q.pend;
    assign tx_byte  = st_q.word[CHAR_W-1:0];
    assign done     = st_q.done;
    assign ie       = st_q.ie;
    assign irq      = st_q.irq;
    assign word     = st_q.word;
    assign cmd      = st_q.cmd;
endmodule

// File: rtl/con_term_port.sv
module con_term_port
    import con_term_pkg::*;
#(
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_byte,
    input  logic              rx_break,
    output logic              rx_ready,
    input  logic [HOLD_W-1:0] hold_cycles,
    output logic              tx_valid,
    output logic [CHAR_W-1:0] tx_byte,
    input  logic              tx_ready,
    output logic              irq_rx,
    output logic              irq_tx,
    output logic              cmd_sw_done,
    output logic              cmd_reboot,
    output logic              cmd_clr_warm,
    output logic              cmd_clr_cold
);
    reg_sel_e            sel;
    logic                rx_done, rx_ie, tx_done, tx_ie;
    logic [WORD_W-1:0]   rx_word, tx_word;
    logic [NUM_CMDS-1:0] cmd;

    assign sel = reg_sel_e'(bus_sel);

    con_rx_side #(.HOLD_W(HOLD_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .stat_wr     (bus_wr && sel == REG_RX_STAT),
        .stat_ie     (bus_wdata[IE_BIT]),
        .data_rd     (bus_rd && sel == REG_RX_DATA),
        .rx_valid    (rx_valid),
        .rx_byte     (rx_byte),
        .rx_break    (rx_break),
        .hold_cycles (hold_cycles),
        .rx_ready    (rx_ready),
        .done        (rx_done),
        .ie          (rx_ie),
        .irq         (irq_rx),
        .word        (rx_word)
    );

    con_tx_side u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_wr  (bus_wr && sel == REG_TX_STAT),
        .stat_ie  (bus_wdata[IE_BIT]),
        .data_wr  (bus_wr && sel == REG_TX_DATA),
        .wdata    (bus_wdata),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_byte  (tx_byte),
        .done     (tx_done),
        .ie       (tx_ie),
        .irq      (irq_tx),
        .word     (tx_word),
        .cmd      (cmd)
    );

    assign cmd_sw_done  = cmd[0];
    assign cmd_reboot   = cmd[1];
    assign cmd_clr_warm = cmd[2];
    assign cmd_clr_cold = cmd[3];

    always_comb begin
        bus_rdata = '0;
        case (sel)
            REG_RX_STAT: begin
                bus_rdata[DONE_BIT] = rx_done;
                bus_rdata[IE_BIT]   = rx_ie;
            end
            REG_RX_DATA: bus_rdata = rx_word;
            REG_TX_STAT: begin
                bus_rdata[DONE_BIT] = tx_done;
                bus_rdata[IE_BIT]   = tx_ie;
            end
            default:     bus_rdata = tx_word;
        endcase
    end
endmodule

// File: rtl/con_term_port_chk.sv
module con_term_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  bus_sel,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic        ie_bit,
    input logic [15:0] bus_rdata,
    input logic        rx_valid,
    input logic        rx_break,
    input logic        rx_ready,
    input logic        tx_valid,
    input logic [7:0]  tx_byte,
    input logic        tx_ready,
    input logic        irq_rx,
    input logic        irq_tx,
    input logic [3:0]  cmds,
    input logic        rx_done,
    input logic        tx_done
);
    logic rx_take;
    assign rx_take = rx_ready && (rx_valid || rx_break);

    AST_STATUS_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel == 2'd0 || bus_sel == 2'd2) |-> ((bus_rdata & 16'hFF3F) == 16'h0)) // R1
        else $error("status reserved bits nonzero");

    AST_IE_CLEAR_DROPS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == 2'd0 && !ie_bit) |=> !irq_rx) // R2
        else $error("rx irq survived IE clear");

    AST_IE_CLEAR_DROPS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == 2'd2 && !ie_bit) |=> !irq_tx) // R2
        else $error("tx irq survived IE clear");

    AST_RX_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |-> rx_done) // R3
        else $error("rx irq without done");

    AST_READ_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_sel == 2'd1 && rx_done && !rx_take) |=> (!rx_done && !irq_rx)) // R5
        else $error("data read did not consume");

    AST_TX_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == 2'd3) |=> (!tx_done && !irq_tx)) // R6
        else $error("tx write did not clear done");

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !(bus_wr && bus_sel == 2'd3)) |=> (tx_valid && $stable(tx_byte))) // R7
        else $error("tx byte dropped before handshake");

    AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmds)) // R9
        else $error("several command strobes");

    AST_HOLD_ONLY_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ready |-> rx_done) // R10
        else $error("receiver blocked while empty");
endmodule

bind con_term_port con_term_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .ie_bit    (bus_wdata[6]),
    .bus_rdata (bus_rdata),
    .rx_valid  (rx_valid),
    .rx_break  (rx_break),
    .rx_ready  (rx_ready),
    .tx_valid  (tx_valid),
    .tx_byte   (tx_byte),
    .tx_ready  (tx_ready),
    .irq_rx    (irq_rx),
    .irq_tx    (irq_tx),
    .cmds      ({cmd_clr_cold, cmd_clr_warm, cmd_reboot, cmd_sw_done}),
    .rx_done   (rx_done),
    .tx_done   (tx_done)
);

// File: tb/con_term_port_test.sv
module con_term_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_sel = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rx_valid = 1'b0, rx_break = 1'b0, rx_ready;
    logic [7:0]  rx_byte = '0;
    logic [15:0] hold_cycles = 16'd20;
    logic        tx_valid, tx_ready = 1'b1;
    logic [7:0]  tx_byte;
    logic        irq_rx, irq_tx;
    logic        cmd_sw_done, cmd_reboot, cmd_clr_warm, cmd_clr_cold;

    int total = 0;
    int bad = 0;
    int expq[$];

    always #5 clk = ~clk;

    con_term_port uut (.*);

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(logic [1:0] s, logic [15:0] d);
        bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] s, output logic [15:0] d);
        bus_sel = s; bus_rd = 1'b1;
        #1 d = bus_rdata;
        tick();
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [1:0] s, logic [15:0] exp);
        logic [15:0] v;
        rd(s, v);
        check(req, int'(v), int'(exp));
    endtask

    task automatic rx_send(logic [7:0] b);
        rx_byte = b; rx_valid = 1'b1;
        tick();
        rx_valid = 1'b0;
    endtask

    // scoreboard monitor: terminal bytes as values, commands as 256 + code
    always @(negedge clk) begin
        if (rst_n) begin
            int got;
            got = -1;
            if (tx_valid && tx_ready) got = int'(tx_byte);
            if (cmd_sw_done)  got = 256 + 1;
            if (cmd_reboot)   got = 256 + 2;
            if (cmd_clr_warm) got = 256 + 3;
            if (cmd_clr_cold) got = 256 + 4;
            if (got >= 0) begin
                if (expq.size() == 0) check("R7/R9 unexpected output", got, -1);
                else check("R7/R9 scoreboard", got, expq.pop_front());
            end
        end
    end

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R12 reset state
        rd_chk("R12 rx status", 2'd0, 16'h0000);
        rd_chk("R12 tx status", 2'd2, 16'h0080);
        rd_chk("R12 rx data", 2'd1, 16'h0000);
        check("R12 irq_rx", int'(irq_rx), 0);
        check("R12 irq_tx", int'(irq_tx), 0);

        // R2 transmit IE handling
        wr(2'd2, 16'h0040);
        check("R2 tx raise", int'(irq_tx), 1);
        wr(2'd2, 16'h0000);
        check("R2 tx drop", int'(irq_tx), 0);
        wr(2'd2, 16'h0040);

        // R6 R7 terminal write with stalled transmitter
        tx_ready = 1'b0;
        expq.push_back(8'h41);
        wr(2'd3, 16'h0041);
        check("R6 irq_tx after write", int'(irq_tx), 0);
        check("R7 tx_valid", int'(tx_valid), 1);
        rd_chk("R6 tx status", 2'd2, 16'h0040);
        check("R7 tx_byte held", int'(tx_byte), 8'h41);
        rd_chk("R6 readback", 2'd3, 16'h0041);
        tx_ready = 1'b1;
        tick();
        check("R7 irq after send", int'(irq_tx), 1);
        rd_chk("R7 done after send", 2'd2, 16'h00C0);
        wr(2'd2, 16'h0000);

        // R8 R9 non-terminal writes
        expq.push_back(256 + 2);
        wr(2'd3, 16'h0F02);
        rd_chk("R8 done low one cycle", 2'd2, 16'h0000);
        rd_chk("R8 done back", 2'd2, 16'h0080);
        check("R8 no terminal", int'(tx_valid), 0);
        expq.push_back(256 + 1);
        wr(2'd3, 16'h0F01); tick();
        expq.push_back(256 + 3);
        wr(2'd3, 16'h0F03); tick();
        expq.push_back(256 + 4);
        wr(2'd3, 16'h0F04); tick();
        wr(2'd3, 16'h0F05); tick();
        wr(2'd3, 16'h0302); tick();
        rd_chk("R6 readback unit", 2'd3, 16'h0302);
        tick();
        check("R9 scoreboard drained", expq.size(), 0);

        // R1 status write keeps only IE
        wr(2'd0, 16'hFFFF);
        rd_chk("R1 rx status", 2'd0, 16'h0040);
        check("R1 no irq", int'(irq_rx), 0);

        // R3 R5 simple receive
        rx_send(8'h5A);
        check("R3 irq_rx", int'(irq_rx), 1);
        rd_chk("R3 rx status", 2'd0, 16'h00C0);
        rd_chk("R3 rx data", 2'd1, 16'h005A);
        check("R5 irq dropped", int'(irq_rx), 0);
        rd_chk("R5 done cleared", 2'd0, 16'h0040);

        // R10 R11 hold-off and overrun
        wr(2'd0, 16'h0000);
        rx_send(8'h11);
        check("R10 held off", int'(rx_ready), 0);
        check("R2 irq stays low", int'(irq_rx), 0);
        repeat (25) tick();
        check("R10 hold expired", int'(rx_ready), 1);
        rx_send(8'h22);
        rd_chk("R11 overrun word", 2'd1, 16'hC022);
        rd_chk("R5 errors cleared", 2'd1, 16'h0022);
        rd_chk("R5 status", 2'd0, 16'h0000);

        // R4 break
        rx_break = 1'b1; tick(); rx_break = 1'b0;
        rd_chk("R4 break word", 2'd1, 16'hA000);
        rd_chk("R4 break cleared", 2'd1, 16'h0000);

        // R2 IE set while done raises request
        rx_send(8'h33);
        check("R2 no irq with IE off", int'(irq_rx), 0);
        wr(2'd0, 16'h0040);
        check("R2 rx raise", int'(irq_rx), 1);
        rd_chk("R3 rx data 2", 2'd1, 16'h0033);
        check("R5 irq dropped 2", int'(irq_rx), 0);

        repeat (3) tick();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule